// File: doc/BRIEF.md
# Delay-Line Tap Rollover Monitor

This block models the tap selection of a tapped delay-line lock loop and watches it for rollover. A lock loop that needs the last tap of its delay line has run out of range. One more step up would move it back to the first tap, and the clock phase would then jump. The monitor keeps the tap index in an up/down counter. The phase detector is replaced by one-cycle adjust-up and adjust-down pulses. The monitor raises a sticky checkstop when checking is armed and the selection is unsafe.

The monitor reports two separate causes. A potential rollover means the last tap is selected; sitting there is fatal by itself. An actual rollover means a single upward step from the last tap to the first. Checking can be armed in two situations. The first is while the loop is enabled but not yet locked, which covers rollover during initial synchronization. The second is once the loop is locked and the cache is turned on. While checking is off, the counter wraps freely modulo the tap count.

Top module: `tap_rollover_mon`

## Requirements
- R1: While `rst` is high, each clock edge sets `tap_sel` to 0 and clears `checkstop`, `cause_last` and `cause_wrap`.
- R2: With `loop_en` high and exactly one adjust pulse, `tap_sel` rises by one on `adj_up` or falls by one on `adj_dn`, at the next clock edge.
- R3: With `loop_en` high and both `adj_up` and `adj_dn` high in the same cycle, `tap_sel` does not change.
- R4: With `loop_en` low, `tap_sel` returns to 0 at the next edge and adjust pulses are ignored.
- R5: The index wraps modulo TAPS. An up step from TAPS-1 gives 0, and a down step from 0 gives TAPS-1.
- R6: Let armed = `chk_en` & `loop_en` & (!`loop_locked` | `cache_en`). When armed and `tap_sel` = TAPS-1 in a cycle, `checkstop` and `cause_last` are 1 after the next edge.
- R7: When armed, `tap_sel` = TAPS-1 and only `adj_up` is high in a cycle, `cause_wrap` is 1 after the next edge.
- R8: While not armed, neither the last tap nor a wrap sets `checkstop`, `cause_last` or `cause_wrap`. This includes the case of a locked loop with the cache off.
- R9: Once set, `checkstop`, `cause_last` and `cause_wrap` stay at 1 until reset, whatever the inputs do.
- R10: A checkstop does not freeze the counter: `tap_sel` keeps following R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adj_up | input | 1 | One-cycle request to move one tap up |
| adj_dn | input | 1 | One-cycle request to move one tap down |
| loop_en | input | 1 | Lock loop enabled |
| loop_locked | input | 1 | Lock loop has reached initial lock |
| cache_en | input | 1 | Cache enabled |
| chk_en | input | 1 | Rollover checking enable |
| tap_sel | output | TAP_W | Current tap index |
| checkstop | output | 1 | Sticky checkstop request |
| cause_last | output | 1 | Sticky flag: last tap selected while armed |
| cause_wrap | output | 1 | Sticky flag: last-to-first step while armed |

## Verification
Directed walks with checking off climb past the last tap and fall below tap 0. They separate the modulo wrap from any checkstop, and they show that simultaneous pulses cancel. Armed walks are run in two arming cases: during initial synchronization, and with the loop locked and the cache on. They separate a step from the last tap into the first, which sets both causes, from simply resting on the last tap, which sets only the potential cause. A locked loop with the cache off is also driven onto the last tap, to show it stays quiet. Long random stretches of mixed pulses, enables and occasional resets are compared cycle by cycle against a reference model in the bench. They show that the flags stay set and that the counter keeps running after a checkstop.

// File: rtl/tap_mon_pkg.sv
package tap_mon_pkg;

  typedef struct packed {
    logic hit_last;
    logic hit_wrap;
  } trip_t;

  function automatic int tap_width(input int taps);
    return (taps > 1) ? $clog2(taps) : 1;
  endfunction

endpackage

// File: rtl/tap_counter.sv
module tap_counter #(
  parameter int TAPS  = 128,
  parameter int TAP_W = tap_mon_pkg::tap_width(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loop_en,
  input  logic             step_up,
  input  logic             step_dn,
  output logic [TAP_W-1:0] tap_q
);
  localparam logic [TAP_W-1:0] LAST  = TAP_W'(TAPS - 1);
  localparam bit               POW2  = (TAPS == (1 << TAP_W));

  logic [TAP_W-1:0] inc_v;
  logic [TAP_W-1:0] dec_v;

  // Power-of-two depth wraps naturally; other depths need explicit compares.
  generate
    if (POW2) begin : g_pow2
      assign inc_v = tap_q + 1'b1;
      assign dec_v = tap_q - 1'b1;
    end else begin : g_mod
      assign inc_v = (tap_q == LAST) ? '0 : tap_q + 1'b1;
      assign dec_v = (tap_q == '0) ? LAST : tap_q - 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !loop_en) begin
      tap_q <= '0;
    end else if (step_up && !step_dn) begin
      tap_q <= inc_v;
    end else if (step_dn && !step_up) begin
      tap_q <= dec_v;
    end
  end
endmodule

// File: rtl/arm_qual.sv
module arm_qual (
  input  logic chk_en,
  input  logic loop_en,
  input  logic loop_locked,
  input  logic cache_en,
  output logic armed
);
  // Armed during initial synchronization, or after lock once the cache runs.
  always_comb begin
    armed = chk_en && loop_en && (!loop_locked || cache_en);
  end
endmodule

// File: rtl/rollover_detect.sv
module rollover_detect
  import tap_mon_pkg::*;
#(
  parameter int TAPS  = 128,
  parameter int TAP_W = tap_width(TAPS)
) (
  input  logic [TAP_W-1:0] tap_q,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             loop_en,
  input  logic             armed,
  output trip_t            trip
);
  localparam logic [TAP_W-1:0] LAST = TAP_W'(TAPS - 1);

  logic on_last;

  always_comb begin
    on_last       = (tap_q == LAST);
    trip.hit_last = armed && on_last;
    trip.hit_wrap = armed && on_last && loop_en && step_up && !step_dn;
  end
endmodule

// File: rtl/checkstop_latch.sv
module checkstop_latch
  import tap_mon_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  trip_t trip,
  output logic  checkstop,
  output trip_t cause
);
  always_ff @(posedge clk) begin
    if (rst) begin
      checkstop <= 1'b0;
      cause     <= '0;
    end else begin
      checkstop <= checkstop || trip.hit_last || trip.hit_wrap;
      cause     <= cause | trip;
    end
  end
endmodule

// File: rtl/tap_rollover_mon.sv
module tap_rollover_mon
  import tap_mon_pkg::*;
#(
  parameter int TAPS  = 128,
  parameter int TAP_W = tap_width(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adj_up,
  input  logic             adj_dn,
  input  logic             loop_en,
  input  logic             loop_locked,
  input  logic             cache_en,
  input  logic             chk_en,
  output logic [TAP_W-1:0] tap_sel,
  output logic             checkstop,
  output logic             cause_last,
  output logic             cause_wrap
);
  logic  armed;
  trip_t trip;
  trip_t cause;

  tap_counter #(.TAPS(TAPS), .TAP_W(TAP_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .loop_en (loop_en),
    .step_up (adj_up),
    .step_dn (adj_dn),
    .tap_q   (tap_sel)
  );

  arm_qual u_arm (
    .chk_en      (chk_en),
    .loop_en     (loop_en),
    .loop_locked (loop_locked),
    .cache_en    (cache_en),
    .armed       (armed)
  );

  rollover_detect #(.TAPS(TAPS), .TAP_W(TAP_W)) u_det (
    .tap_q   (tap_sel),
    .step_up (adj_up),
    .step_dn (adj_dn),
    .loop_en (loop_en),
    .armed   (armed),
    .trip    (trip)
  );

  checkstop_latch u_lat (
    .clk       (clk),
    .rst       (rst),
    .trip      (trip),
    .checkstop (checkstop),
    .cause     (cause)
  );

  assign cause_last = cause.hit_last;
  assign cause_wrap = cause.hit_wrap;
endmodule

// File: rtl/tap_rollover_mon_chk.sv
module tap_rollover_mon_chk #(
  parameter int TAPS  = 128,
  parameter int TAP_W = tap_mon_pkg::tap_width(TAPS)
) (
  input logic             clk,
  input logic             rst,
  input logic             adj_up,
  input logic             adj_dn,
  input logic             loop_en,
  input logic             loop_locked,
  input logic             cache_en,
  input logic             chk_en,
  input logic [TAP_W-1:0] tap_sel,
  input logic             checkstop,
  input logic             cause_last,
  input logic             cause_wrap
);
  localparam logic [TAP_W-1:0] LAST = TAP_W'(TAPS - 1);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (tap_sel == '0) && !checkstop && !cause_last && !cause_wrap);

  a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
    (loop_en && adj_up && !adj_dn && tap_sel != LAST) |=> tap_sel == $past(tap_sel) + 1'b1);

  a_r3_cancel: assert property (@(posedge clk) disable iff (rst)
    (loop_en && adj_up && adj_dn) |=> $stable(tap_sel));

  a_r4_loop_off: assert property (@(posedge clk) disable iff (rst)
    !loop_en |=> tap_sel == '0);

  a_r6_last_trips: assert property (@(posedge clk) disable iff (rst)
    (chk_en && loop_en && (!loop_locked || cache_en) && tap_sel == LAST) |=> checkstop && cause_last);

  a_r8_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(checkstop) |-> $past(chk_en) && $past(loop_en));

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    checkstop |=> checkstop);
endmodule

bind tap_rollover_mon tap_rollover_mon_chk #(.TAPS(TAPS), .TAP_W(TAP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .adj_up      (adj_up),
  .adj_dn      (adj_dn),
  .loop_en     (loop_en),
  .loop_locked (loop_locked),
  .cache_en    (cache_en),
  .chk_en      (chk_en),
  .tap_sel     (tap_sel),
  .checkstop   (checkstop),
  .cause_last  (cause_last),
  .cause_wrap  (cause_wrap)
);

// File: tb/sim_tap_rollover_mon.sv
`timescale 1ns/1ps
module sim_tap_rollover_mon;
  localparam int TAPS  = 16;
  localparam int TAP_W = 4;
  localparam int LAST  = TAPS - 1;

  logic clk = 1'b0;
  logic rst, adj_up, adj_dn, loop_en, loop_locked, cache_en, chk_en;
  logic [TAP_W-1:0] tap_sel;
  logic checkstop, cause_last, cause_wrap;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int m_tap;
  bit m_cs, m_cl, m_cw;

  always #2.5 clk = ~clk;

  tap_rollover_mon #(.TAPS(TAPS)) u0 (
    .clk(clk), .rst(rst), .adj_up(adj_up), .adj_dn(adj_dn),
    .loop_en(loop_en), .loop_locked(loop_locked), .cache_en(cache_en),
    .chk_en(chk_en), .tap_sel(tap_sel), .checkstop(checkstop),
    .cause_last(cause_last), .cause_wrap(cause_wrap)
  );

  function automatic int next_tap(int t, bit up, bit dn, bit le, bit r);
    if (r || !le) return 0;
    if (up && !dn) return (t == LAST) ? 0 : t + 1;
    if (dn && !up) return (t == 0) ? LAST : t - 1;
    return t;
  endfunction

  function automatic bit is_armed(bit ck, bit le, bit lk, bit ce);
    return ck && le && (!lk || ce);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle(bit up, bit dn, bit le, bit lk, bit ce, bit ck, bit r);
    bit arm, was_cs;
    string ttag, ctag;
    adj_up = up; adj_dn = dn; loop_en = le; loop_locked = lk;
    cache_en = ce; chk_en = ck; rst = r;
    arm = is_armed(ck, le, lk, ce);
    was_cs = m_cs;
    if (r) ttag = "R1";
    else if (was_cs) ttag = "R10";
    else if (!le) ttag = "R4";
    else if (up && dn) ttag = "R3";
    else if ((up && m_tap == LAST) || (dn && m_tap == 0)) ttag = "R5";
    else ttag = "R2";
    if (r) ctag = "R1";
    else if (was_cs) ctag = "R9";
    else if (arm) ctag = "R6";
    else ctag = "R8";
    if (r) begin
      m_cs = 0; m_cl = 0; m_cw = 0;
    end else begin
      if (arm && m_tap == LAST) begin m_cs = 1; m_cl = 1; end
      if (arm && m_tap == LAST && up && !dn) m_cw = 1;
    end
    m_tap = next_tap(m_tap, up, dn, le, r);
    @(posedge clk);
    #1;
    check(ttag, int'(tap_sel), m_tap);
    check(ctag, int'(checkstop), int'(m_cs));
    check(ctag, int'(cause_last), int'(m_cl));
    check((r || was_cs) ? ctag : (arm ? "R7" : "R8"), int'(cause_wrap), int'(m_cw));
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; adj_up = 0; adj_dn = 0; loop_en = 0; loop_locked = 0;
    cache_en = 0; chk_en = 0;
    m_tap = 0; m_cs = 0; m_cl = 0; m_cw = 0;
    // R1 reset state
    cycle(0, 0, 0, 0, 0, 0, 1);
    cycle(1, 0, 1, 0, 0, 1, 1);
    // R2 up and down, checking off
    for (int i = 0; i < 5; i++) cycle(1, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 2; i++) cycle(0, 1, 1, 0, 0, 0, 0);
    // R3 cancel
    cycle(1, 1, 1, 0, 0, 0, 0);
    // R5 wrap upward and downward with no checkstop (R8)
    for (int i = 0; i < TAPS; i++) cycle(1, 0, 1, 1, 1, 0, 0);
    for (int i = 0; i < 4; i++) cycle(0, 1, 1, 1, 1, 0, 0);
    // R4 loop off resets and ignores pulses
    cycle(1, 0, 0, 0, 0, 1, 0);
    cycle(0, 1, 0, 0, 0, 1, 0);
    // R8 locked, cache off, sitting on last tap
    cycle(0, 1, 1, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) cycle(0, 0, 1, 1, 0, 1, 0);
    cycle(1, 0, 1, 1, 0, 1, 0);
    cycle(0, 1, 1, 1, 0, 1, 0);
    // R6 cache turned on: last tap alone trips, no wrap cause
    cycle(0, 0, 1, 1, 1, 1, 0);
    cycle(0, 0, 1, 1, 1, 1, 0);
    // R10 counter keeps moving, R9 sticky with checking off
    for (int i = 0; i < 3; i++) cycle(1, 0, 1, 1, 1, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 1);
    // R7 wrap during initial synchronization
    for (int i = 0; i < TAPS + 1; i++) cycle(1, 0, 1, 0, 0, 1, 0);
    cycle(0, 0, 1, 0, 0, 1, 1);
    // Random stretch
    for (int i = 0; i < 4000; i++) begin
      bit r = ($urandom_range(199) == 0);
      bit ck = ($urandom_range(5) == 0);
      bit le = ($urandom_range(31) != 0);
      bit lk = $urandom_range(1);
      bit ce = $urandom_range(1);
      bit up = ($urandom_range(2) != 0);
      bit dn = ($urandom_range(3) == 0);
      cycle(up, dn, le, lk, ce, ck, r);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule